// File: doc/BRIEF.md
# Dual-Channel Edge-Latched Word Loader

This block loads data words into two converter channels from a parallel host bus. Each channel has its own active-low select and one output register. Both channels share a single active-low write strobe. A channel is enabled while its select and the write strobe are both low. The channel register takes the bus word when that enabled state ends, which happens on the rising edge of whichever of the two signals returns high first. When both selects are low during a write, one write loads the same word into both channels.

The strobes arrive without any timing relation to the block clock. Each one passes through a synchronizer chain, and the end of a write is found by comparing the current synchronized level with the one from the previous cycle. The bus goes through a register pipeline one stage longer than the synchronizers. As a result, the word that gets stored is the one present on the bus one clock before the first synchronizer stage saw the terminating edge. A one-cycle done pulse per channel marks each load.

Top module: `dual_word_loader`

## Requirements
- R1: While reset is asserted, both channel registers read zero and both done outputs are low.
- R2: While the write strobe stays high, neither channel register changes and no done pulse appears, whatever the selects do.
- R3: A write strobe cycle made while both selects are high transfers nothing to either channel.
- R4: A rising write strobe with only select A low loads only channel A. With only select B low it loads only channel B. The other register keeps its value.
- R5: A rising write strobe with both selects low loads the same bus word into both channels.
- R6: With the write strobe held low, a rising edge on a select loads that channel. Rising edges on both selects in the same cycle load both channels. Raising the strobe afterwards, with the selects already high, loads nothing.
- R7: The stored word is the low WORD_W bits of the bus, with bit WORD_W-1 as the most significant bit. The value taken is the one sampled on the clock edge before the terminating rise reaches the first synchronizer stage. A bus change in the same cycle as that rise is not taken, and bus bits above WORD_W are ignored.
- R8: Each loaded channel raises its done output for exactly one cycle, in the same cycle its register takes the new word. This happens SYNC_STAGES+1 rising clock edges after the terminating rise is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Shared active-low write strobe, asynchronous |
| sel_a_n | input | 1 | Active-low select for channel A, asynchronous |
| sel_b_n | input | 1 | Active-low select for channel B, asynchronous |
| bus_d | input | BUS_W | Parallel data bus |
| word_a | output | WORD_W | Channel A register |
| word_b | output | WORD_W | Channel B register |
| done_a | output | 1 | One-cycle pulse when channel A is loaded |
| done_b | output | 1 | One-cycle pulse when channel B is loaded |

## Verification
The assertions assume that every strobe level is held for at least two clock cycles, so that the synchronizers see each active phase. They also assume that the bus is stable from at least one clock before a terminating rise. Under these conditions two loads of one channel can never fall on adjacent cycles, and a broadcast always stores a single word in both registers. The stimulus changes inputs only on falling clock edges and holds each strobe level for two or more cycles. It places new data on the bus two cycles before a write ends, and it deliberately changes the bus in the same cycle as the terminating rise to show that only the older value is taken.

// File: rtl/dual_word_loader.sv
module dual_word_loader #(
  parameter int WORD_W      = 12,
  parameter int BUS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic [BUS_W-1:0]  bus_d,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic              done_a,
  output logic              done_b
);
  localparam int DLY = SYNC_STAGES + 1;

  logic [SYNC_STAGES:0] wr_p, sa_p, sb_p;
  logic [WORD_W-1:0]    dpipe [DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '1;
      sa_p <= '1;
      sb_p <= '1;
    end else begin
      wr_p <= {wr_p[SYNC_STAGES-1:0], wr_n};
      sa_p <= {sa_p[SYNC_STAGES-1:0], sel_a_n};
      sb_p <= {sb_p[SYNC_STAGES-1:0], sel_b_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) dpipe[i] <= '0;
    end else begin
      dpipe[0] <= bus_d[WORD_W-1:0];
      for (int i = 1; i < DLY; i++) dpipe[i] <= dpipe[i-1];
    end
  end

  logic wr_now, wr_prev, sa_now, sa_prev, sb_now, sb_prev;
  assign wr_now  = wr_p[SYNC_STAGES-1];
  assign wr_prev = wr_p[SYNC_STAGES];
  assign sa_now  = sa_p[SYNC_STAGES-1];
  assign sa_prev = sa_p[SYNC_STAGES];
  assign sb_now  = sb_p[SYNC_STAGES-1];
  assign sb_prev = sb_p[SYNC_STAGES];

  logic cap_a, cap_b;
  assign cap_a = !(sa_prev || wr_prev) && (sa_now || wr_now);
  assign cap_b = !(sb_prev || wr_prev) && (sb_now || wr_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
      done_a <= 1'b0;
      done_b <= 1'b0;
    end else begin
      done_a <= cap_a;
      done_b <= cap_b;
      if (cap_a) word_a <= dpipe[DLY-1];
      if (cap_b) word_b <= dpipe[DLY-1];
    end
  end
endmodule

// File: rtl/dual_word_loader_chk.sv
module dual_word_loader_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_now,
  input logic              wr_prev,
  input logic              sa_now,
  input logic              sa_prev,
  input logic              sb_now,
  input logic              sb_prev,
  input logic [WORD_W-1:0] word_a,
  input logic [WORD_W-1:0] word_b,
  input logic              done_a,
  input logic              done_b
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (word_a == '0 && word_b == '0 && !done_a && !done_b));

  assert_wr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && wr_prev) |=> (!done_a && !done_b));

  assert_sel_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_now && sa_prev && sb_now && sb_prev) |=> (!done_a && !done_b));

  assert_other_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_a && !done_b) |-> word_b == $past(word_b));

  assert_broadcast_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_a && done_b) |-> word_a == word_b);

  assert_pulse_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_a |=> !done_a);

  assert_pulse_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_b |=> !done_b);

  assert_change_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_a != $past(word_a)) |-> done_a);

  assert_change_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_b != $past(word_b)) |-> done_b);
endmodule

bind dual_word_loader dual_word_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_now(wr_now), .wr_prev(wr_prev),
  .sa_now(sa_now), .sa_prev(sa_prev),
  .sb_now(sb_now), .sb_prev(sb_prev),
  .word_a(word_a), .word_b(word_b),
  .done_a(done_a), .done_b(done_b)
);

// File: tb/tb_dual_word_loader.sv
module tb_dual_word_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 12;
  localparam int BW = 16;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1;
  logic [BW-1:0] bus_d = '0;
  logic [WW-1:0] word_a, word_b;
  logic done_a, done_b;

  int total = 0;
  int fails = 0;
  logic [WW-1:0] exp_a = '0, exp_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_word_loader #(.WORD_W(WW), .BUS_W(BW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .bus_d(bus_d), .word_a(word_a), .word_b(word_b), .done_a(done_a), .done_b(done_b));

  // {sel_a_n, sel_b_n, ends_by_select, bus word}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 16'h0A5C},
    {1'b1, 1'b0, 1'b0, 16'h03F1},
    {1'b0, 1'b0, 1'b0, 16'h0FFF},
    {1'b1, 1'b1, 1'b0, 16'h0123},
    {1'b0, 1'b1, 1'b1, 16'h0800},
    {1'b1, 1'b0, 1'b1, 16'h07FF},
    {1'b0, 1'b0, 1'b1, 16'hF001},
    {1'b1, 1'b1, 1'b1, 16'h0555}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic run_vec(input logic sa, input logic sb, input logic bysel, input logic [BW-1:0] d);
    string tag;
    if (sa && sb) tag = "R3";
    else if (bysel) tag = "R6";
    else if (!sa && !sb) tag = "R5";
    else tag = "R4";
    @(negedge clk);
    bus_d = d; wr_n = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1;
    repeat (2) @(negedge clk);
    if (!bysel) begin
      sel_a_n = sa; sel_b_n = sb; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1; bus_d = ~d;              // R7: coincident change not taken
    end else begin
      wr_n = 1'b0;
      repeat (2) @(negedge clk);
      sel_a_n = sa; sel_b_n = sb;
      repeat (3) @(negedge clk);
      sel_a_n = 1'b1; sel_b_n = 1'b1; bus_d = ~d;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (!sa) exp_a = d[WW-1:0];
    if (!sb) exp_b = d[WW-1:0];
    chk({tag, " R7 word_a"}, 32'(word_a), 32'(exp_a));
    chk({tag, " R7 word_b"}, 32'(word_b), 32'(exp_b));
    chk("R8 done at load", {30'b0, done_a, done_b}, {30'b0, !sa, !sb});
    @(negedge clk);
    chk("R8 done one cycle", {30'b0, done_a, done_b}, 32'b0);
    if (bysel) begin
      wr_n = 1'b1;                            // R6: late strobe rise loads nothing
      repeat (5) @(negedge clk);
      chk("R6 late strobe rise", {8'b0, word_a, word_b}, {8'b0, exp_a, exp_b});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit saw_done;
    repeat (3) @(negedge clk);
    chk("R1 reset words", {8'b0, word_a, word_b}, 32'b0);
    chk("R1 reset done", {30'b0, done_a, done_b}, 32'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);

    // R2: selects toggle while strobe stays high
    saw_done = 1'b0;
    bus_d = 16'h0BAD;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sel_a_n = 1'b0; saw_done |= done_a | done_b;
      repeat (2) @(negedge clk); sel_b_n = 1'b0; saw_done |= done_a | done_b;
      repeat (2) @(negedge clk); sel_a_n = 1'b1; sel_b_n = 1'b1; saw_done |= done_a | done_b;
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); saw_done |= done_a | done_b;
    end
    chk("R2 no done with strobe high", 32'(saw_done), 32'b0);
    chk("R2 words unchanged", {8'b0, word_a, word_b}, {8'b0, exp_a, exp_b});

    // R7: data must be present a clock before the rise; too-late data ignored
    @(negedge clk);
    bus_d = 16'h0111; sel_a_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_d = 16'h0222;
    wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 earlier bus value stored", 32'(word_a), 32'h111);
    sel_a_n = 1'b1;
    exp_a = 12'h111;

    // R1: reset mid-run clears both channels
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears words", {8'b0, word_a, word_b}, 32'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule